// File: doc/BRIEF.md
# Gated Interval Timer

A single 16-bit interval timer channel clocked from the bus clock. Each step advances the count by one. A step comes from the undivided bus clock, from one of two fixed prescaler taps, or from the rising edge of a horizontal-blank input. A target comparator and overflow detection each latch a sticky flag and can raise one interrupt request line. An optional gate, taken from the horizontal- or vertical-blank input, can pause counting while the blank is high. The gate can instead restart the count from zero on blank edges.

Software reaches the channel through a flat register port with four 32-bit slots:

| Offset | Register |
|---|---|
| 0 | count |
| 1 | mode |
| 2 | target |
| 3 | hold |

Reads are combinational from the address. Writes take effect at the clock edge. The blank signals come from elsewhere and must already be in the timer's clock domain.

Top module: `gated_interval_timer`

## Requirements
- R1: After reset, reads return count 0, mode 0, target 0x0000FFFF and hold 0, and `irq_o` is low. Every read returns zero in bits 31:16. The offsets are count 0, mode 1, target 2 and hold 3.
- R2: Counting happens only while mode bit 7 is set. Mode bits 1:0 choose the step:
  - 0: every bus clock
  - 1: every 16 bus clocks
  - 2: every 256 bus clocks
  - 3: each rising edge of `hblank_i`
- R3: The count is 16 bits wide and wraps from 0xFFFF to 0. On a wrap, if mode bit 9 is set and the overflow flag (mode bit 11) is clear, the flag is set and an interrupt is raised.
- R4: When an armed target is met or passed (count >= target), and mode bit 8 is set with the target flag (mode bit 10) clear, the flag is set and an interrupt is raised. If mode bit 6 is set, the count restarts from 0 and the target stays armed. Otherwise the target is disarmed until the next wrap.
- R5: Within one step the wrap is handled before the target compare. With target 0 and count 0xFFFF, a single step sets both flags, leaves the count at 0 and gives exactly one interrupt pulse.
- R6: A mode write stores bits 9:0 as written. Writing 1 to bit 11 or bit 10 clears that flag. Writing 0 to either leaves it unchanged.
- R7: Count and target writes load bits 15:0 of the write data. After either write, a target at or below the count stays disarmed until the next wrap.
- R8: `irq_o` is high for one cycle after each step in which a flag becomes newly set. A step that finds a flag already set gives no pulse.
- R9: Mode bit 2 enables the gate and bit 3 selects its source (0 for hblank, 1 for vblank). A mode write that enables a gate clears the count and halts counting until the gate releases it. Gate mode 0 (bits 5:4 = 0) counts only while the gate signal is low.
- R10: Gate mode 1 restarts the count at 0 and runs on the gate signal's rising edge. Gate mode 2 does the same on the falling edge, and gate mode 3 on both edges. An edge that does not belong to the selected mode has no effect.
- R11: If the gate source is hblank and the step source is also hblank, the gate is ignored. In that case the mode write does not clear the count, and the channel counts hblank edges.
- R12: Offset 3 stores bits 15:0 of the write data and affects nothing else.
- R13: Any register write cycle takes precedence over a count step and a gate restart in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register slot select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected slot |
| hblank_i | input | 1 | Horizontal blank level |
| vblank_i | input | 1 | Vertical blank level |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The wrap and the target compare can land in the same step. The bench provokes this by writing target 0 and count 0xFFFF while counting is halted, so the target starts out disarmed, and then enabling both interrupts. After one step, the bench expects both flags set, a zero count and a single interrupt pulse. In the following steps it expects the target to stay quiet. A register write that meets a pending step in the same cycle is judged by counting whole steps over windows that exclude the write edge.

// File: rtl/gpit_pkg.sv
package gpit_pkg;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
  localparam logic [1:0] ADDR_TARGET = 2'd2;
  localparam logic [1:0] ADDR_HOLD   = 2'd3;

  localparam logic [1:0] CLK_BUS    = 2'd0;
  localparam logic [1:0] CLK_DIV_A  = 2'd1;
  localparam logic [1:0] CLK_DIV_B  = 2'd2;
  localparam logic [1:0] CLK_HBLANK = 2'd3;

  localparam logic [1:0] GATE_LEVEL = 2'd0;
  localparam logic [1:0] GATE_RISE  = 2'd1;
  localparam logic [1:0] GATE_FALL  = 2'd2;
  localparam logic [1:0] GATE_BOTH  = 2'd3;

  localparam int unsigned OVF_BIT = 11;
  localparam int unsigned TGT_BIT = 10;

  // bit 11 down to bit 0
  typedef struct packed {
    logic       ovf_flag;
    logic       tgt_flag;
    logic       ovf_irq_en;
    logic       tgt_irq_en;
    logic       cnt_en;
    logic       zero_ret;
    logic [1:0] gate_mode;
    logic       gate_src;
    logic       gate_en;
    logic [1:0] clk_sel;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);

endpackage

// File: rtl/gpit_prescaler.sv
module gpit_prescaler
  import gpit_pkg::*;
#(
  parameter int unsigned DIV_A_LOG2 = 4,
  parameter int unsigned DIV_B_LOG2 = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] clk_sel_i,
  input  logic       hblank_rise_i,
  output logic       tick_o
);

  logic [DIV_B_LOG2-1:0] pre_q;
  logic tick_a, tick_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  generate
    if (DIV_A_LOG2 == 0) begin : g_tap_a_bus
      assign tick_a = 1'b1;
    end else begin : g_tap_a_div
      assign tick_a = &pre_q[DIV_A_LOG2-1:0];
      // R2: a divided tap never fires on two consecutive clocks
      assert_tap_a_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_a |=> !tick_a);
    end
  endgenerate

  assign tick_b = &pre_q;

  always_comb begin
    case (clk_sel_i)
      CLK_BUS:   tick_o = 1'b1;
      CLK_DIV_A: tick_o = tick_a;
      CLK_DIV_B: tick_o = tick_b;
      default:   tick_o = hblank_rise_i;
    endcase
  end

endmodule

// File: rtl/gpit_gate.sv
module gpit_gate
  import gpit_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hblank_i,
  input  logic       vblank_i,
  input  logic       gate_on_i,
  input  logic       gate_src_i,
  input  logic [1:0] gate_mode_i,
  input  logic       cnt_en_i,
  input  logic       gate_clear_i,
  output logic       hblank_rise_o,
  output logic       gate_pass_o,
  output logic       restart_o
);

  logic hb_q, vb_q, run_q;
  logic sig, sig_q, rise, fall, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q <= 1'b0;
      vb_q <= 1'b0;
    end else begin
      hb_q <= hblank_i;
      vb_q <= vblank_i;
    end
  end

  assign hblank_rise_o = hblank_i & ~hb_q;

  assign sig   = gate_src_i ? vblank_i : hblank_i;
  assign sig_q = gate_src_i ? vb_q : hb_q;
  assign rise  = sig & ~sig_q;
  assign fall  = ~sig & sig_q;

  always_comb begin
    case (gate_mode_i)
      GATE_RISE: edge_hit = rise;
      GATE_FALL: edge_hit = fall;
      GATE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

  assign restart_o = gate_on_i && cnt_en_i && edge_hit;

  // run_q: edge-restart modes hold until their first restart edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= 1'b0;
    else if (gate_clear_i) run_q <= 1'b0;
    else if (restart_o)    run_q <= 1'b1;
  end

  assign gate_pass_o = !gate_on_i || ((gate_mode_i == GATE_LEVEL) ? !sig : run_q);

  assert_clear_halts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_clear_i |=> !run_q);

  assert_level_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_on_i && gate_mode_i == GATE_LEVEL && sig) |-> !gate_pass_o);

endmodule

// File: rtl/gpit_core.sv
module gpit_core
  import gpit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              gate_pass_i,
  input  logic              gate_restart_i,
  output mode_t             mode_o,
  output logic              gate_on_o,
  output logic              gate_clear_o,
  output logic              irq_o
);

  mode_t            mode_q, mode_new;
  logic [CNT_W-1:0] cnt_q, tgt_q, hold_q;
  logic             armed_q, irq_q;

  logic wr_cnt, wr_mode, wr_tgt, wr_hold;
  logic step;
  logic [CNT_W:0]   inc;
  logic [CNT_W-1:0] after, cnt_step;
  logic wrap, armed_mid, hit, ovf_new, tgt_new, armed_step;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:MODE_W];

  function automatic logic gate_effective(input mode_t m);
    return m.gate_en && !(!m.gate_src && m.clk_sel == CLK_HBLANK);
  endfunction

  assign wr_cnt  = wr_i && addr_i == ADDR_COUNT;
  assign wr_mode = wr_i && addr_i == ADDR_MODE;
  assign wr_tgt  = wr_i && addr_i == ADDR_TARGET;
  assign wr_hold = wr_i && addr_i == ADDR_HOLD;

  always_comb begin
    mode_new          = mode_t'(wdata_i[MODE_W-1:0]);
    mode_new.ovf_flag = mode_q.ovf_flag & ~wdata_i[OVF_BIT];
    mode_new.tgt_flag = mode_q.tgt_flag & ~wdata_i[TGT_BIT];
  end

  assign gate_on_o    = gate_effective(mode_q);
  assign gate_clear_o = wr_mode && gate_effective(mode_new);
  assign step         = tick_i && mode_q.cnt_en && gate_pass_i;

  // wrap is resolved first so that a zero target sees the wrapped count
  always_comb begin
    inc        = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    wrap       = inc[CNT_W];
    after      = inc[CNT_W-1:0];
    armed_mid  = armed_q | wrap;
    hit        = armed_mid && (after >= tgt_q);
    ovf_new    = wrap && mode_q.ovf_irq_en && !mode_q.ovf_flag;
    tgt_new    = hit && mode_q.tgt_irq_en && !mode_q.tgt_flag;
    cnt_step   = (hit && mode_q.zero_ret) ? after - tgt_q : after;
    armed_step = armed_mid && !(hit && !mode_q.zero_ret);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      cnt_q   <= '0;
      tgt_q   <= '1;
      hold_q  <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_i) begin
        if (wr_cnt) begin
          cnt_q   <= wdata_i[CNT_W-1:0];
          armed_q <= tgt_q > wdata_i[CNT_W-1:0];
        end
        if (wr_mode) begin
          mode_q <= mode_new;
          if (gate_effective(mode_new)) cnt_q <= '0;
        end
        if (wr_tgt) begin
          tgt_q   <= wdata_i[CNT_W-1:0];
          armed_q <= wdata_i[CNT_W-1:0] > cnt_q;
        end
        if (wr_hold) hold_q <= wdata_i[CNT_W-1:0];
      end else if (gate_restart_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (step) begin
        cnt_q   <= cnt_step;
        armed_q <= armed_step;
        irq_q   <= ovf_new | tgt_new;
        if (ovf_new) mode_q.ovf_flag <= 1'b1;
        if (tgt_new) mode_q.tgt_flag <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_COUNT:  rdata_o = DATA_W'(cnt_q);
      ADDR_MODE:   rdata_o = DATA_W'(mode_q);
      ADDR_TARGET: rdata_o = DATA_W'(tgt_q);
      default:     rdata_o = DATA_W'(hold_q);
    endcase
  end

  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  assert_w1c_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mode && wdata_i[OVF_BIT]) |=> !mode_q.ovf_flag);

  assert_w1c_tgt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mode && wdata_i[TGT_BIT]) |=> !mode_q.tgt_flag);

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.ovf_flag && !wr_mode) |=> mode_q.ovf_flag);

  assert_irq_new_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ((mode_q.ovf_flag && !$past(mode_q.ovf_flag)) ||
               (mode_q.tgt_flag && !$past(mode_q.tgt_flag))));

  assert_idle_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.cnt_en && !wr_i) |=> $stable(cnt_q));

  assert_wrap_to_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == {CNT_W{1'b1}} && step && !wr_i && !gate_restart_i) |=> cnt_q == '0);

  assert_write_wins_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_cnt && !gate_clear_o) |=> $stable(cnt_q));

endmodule

// File: rtl/gated_interval_timer.sv
module gated_interval_timer
  import gpit_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DIV_A_LOG2 = 4,
  parameter int unsigned DIV_B_LOG2 = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              hblank_i,
  input  logic              vblank_i,
  output logic              irq_o
);

  mode_t mode;
  logic  tick, hblank_rise, gate_pass, gate_restart, gate_on, gate_clear;

  gpit_prescaler #(
    .DIV_A_LOG2(DIV_A_LOG2),
    .DIV_B_LOG2(DIV_B_LOG2)
  ) u_pre (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clk_sel_i     (mode.clk_sel),
    .hblank_rise_i (hblank_rise),
    .tick_o        (tick)
  );

  gpit_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hblank_i      (hblank_i),
    .vblank_i      (vblank_i),
    .gate_on_i     (gate_on),
    .gate_src_i    (mode.gate_src),
    .gate_mode_i   (mode.gate_mode),
    .cnt_en_i      (mode.cnt_en),
    .gate_clear_i  (gate_clear),
    .hblank_rise_o (hblank_rise),
    .gate_pass_o   (gate_pass),
    .restart_o     (gate_restart)
  );

  gpit_core #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (reg_wr_i),
    .addr_i         (reg_addr_i),
    .wdata_i        (reg_wdata_i),
    .rdata_o        (reg_rdata_o),
    .tick_i         (tick),
    .gate_pass_i    (gate_pass),
    .gate_restart_i (gate_restart),
    .mode_o         (mode),
    .gate_on_o      (gate_on),
    .gate_clear_o   (gate_clear),
    .irq_o          (irq_o)
  );

endmodule

// File: tb/tb_gated_interval_timer.sv
`timescale 1ns/1ps
module tb_gated_interval_timer;

  localparam logic [1:0] A_CNT = 2'd0, A_MODE = 2'd1, A_TGT = 2'd2, A_HOLD = 2'd3;
  localparam logic [31:0] CNT_EN = 32'h80, TGT_EN = 32'h100, OVF_EN = 32'h200,
                          ZR = 32'h40, GATE_EN = 32'h4, SRC_V = 32'h8,
                          GM1 = 32'h10, GM2 = 32'h20, GM3 = 32'h30,
                          CS16 = 32'h1, CS256 = 32'h2, CSH = 32'h3,
                          TGT_F = 32'h400, OVF_F = 32'h800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hblank = 1'b0, vblank = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  int irq_seen = 0;
  int base;

  always #10 clk = ~clk;

  gated_interval_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hblank_i(hblank),
    .vblank_i(vblank), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    #1;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic hpulse();
    @(negedge clk); hblank = 1'b1;
    repeat (2) @(negedge clk);
    hblank = 1'b0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk_reg("R1 count", A_CNT, 32'h0);
    chk_reg("R1 mode", A_MODE, 32'h0);
    chk_reg("R1 target", A_TGT, 32'h0000FFFF);
    chk_reg("R1 hold", A_HOLD, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_hold();
    wr_reg(A_HOLD, 32'h5A5A_C3C3);
    chk_reg("R12 hold low half", A_HOLD, 32'h0000C3C3);
    chk_reg("R12 count untouched", A_CNT, 32'h0);
    chk_reg("R12 mode untouched", A_MODE, 32'h0);
  endtask

  task automatic t_clock_sources();
    wr_reg(A_MODE, CNT_EN);
    step(5);
    chk_reg("R2 bus clock", A_CNT, 32'd5);
    wr_reg(A_MODE, 32'h0);
    step(5);
    chk_reg("R2 disabled holds", A_CNT, 32'd6);
    wr_reg(A_CNT, 32'h0);
    wr_reg(A_MODE, CNT_EN | CS16);
    step(64);
    chk_reg("R2 div16", A_CNT, 32'd4);
    wr_reg(A_MODE, 32'h0);
    wr_reg(A_CNT, 32'h0);
    wr_reg(A_MODE, CNT_EN | CS256);
    step(512);
    chk_reg("R2 div256", A_CNT, 32'd2);
    wr_reg(A_MODE, 32'h0);
    wr_reg(A_CNT, 32'h0);
    wr_reg(A_MODE, CNT_EN | CSH);
    repeat (3) hpulse();
    chk_reg("R2 hblank clock", A_CNT, 32'd3);
  endtask

  task automatic t_overflow();
    wr_reg(A_MODE, OVF_F | TGT_F);
    wr_reg(A_CNT, 32'h0000FFFE);
    wr_reg(A_MODE, CNT_EN | OVF_EN);
    base = irq_seen;
    step(2);
    chk_reg("R3 wrapped", A_CNT, 32'h0);
    chk_reg("R3 ovf flag", A_MODE, OVF_F | CNT_EN | OVF_EN);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    step(1);
    chk("R8 irq one cycle", {31'b0, irq}, 32'h0);
    chk("R8 one pulse", irq_seen - base, 32'd1);
    wr_reg(A_CNT, 32'hABCD_FFFF);
    base = irq_seen;
    step(2);
    chk_reg("R3 second wrap", A_CNT, 32'd1);
    chk("R8 no pulse when flag set", irq_seen - base, 32'd0);
  endtask

  task automatic t_same_step();
    wr_reg(A_MODE, OVF_F | TGT_F);
    wr_reg(A_CNT, 32'h0);
    wr_reg(A_TGT, 32'h0);
    wr_reg(A_CNT, 32'h0000FFFF);
    wr_reg(A_MODE, CNT_EN | TGT_EN | OVF_EN);
    base = irq_seen;
    step(1);
    chk_reg("R5 count zero", A_CNT, 32'h0);
    chk_reg("R5 both flags", A_MODE, OVF_F | TGT_F | CNT_EN | TGT_EN | OVF_EN);
    step(3);
    chk_reg("R5 counts on", A_CNT, 32'd3);
    chk("R5 single pulse", irq_seen - base, 32'd1);
    // R6 clear one flag, other kept, low bits stored
    wr_reg(A_MODE, OVF_F);
    chk_reg("R6 ovf cleared tgt kept", A_MODE, TGT_F);
    wr_reg(A_MODE, TGT_F | 32'h163);
    chk_reg("R6 tgt cleared low bits stored", A_MODE, 32'h163);
    wr_reg(A_MODE, 32'h0);
  endtask

  task automatic t_target();
    wr_reg(A_MODE, OVF_F | TGT_F);
    wr_reg(A_CNT, 32'h0);
    wr_reg(A_TGT, 32'd3);
    wr_reg(A_MODE, CNT_EN | TGT_EN | ZR);
    base = irq_seen;
    step(3);
    chk_reg("R4 zero return count", A_CNT, 32'h0);
    chk_reg("R4 tgt flag", A_MODE, TGT_F | CNT_EN | TGT_EN | ZR);
    chk("R4 irq", {31'b0, irq}, 32'h1);
    step(3);
    chk_reg("R4 rearmed restart", A_CNT, 32'h0);
    chk("R8 flag already set no pulse", irq_seen - base, 32'd1);

    wr_reg(A_MODE, TGT_F);
    wr_reg(A_CNT, 32'h0);
    wr_reg(A_MODE, CNT_EN | TGT_EN);
    step(3);
    chk_reg("R4 no zero return", A_CNT, 32'd3);
    wr_reg(A_MODE, TGT_F | CNT_EN | TGT_EN);
    step(4);
    chk_reg("R4 count runs on", A_CNT, 32'd8);
    chk_reg("R4 disarmed no refire", A_MODE, CNT_EN | TGT_EN);
  endtask

  task automatic t_target_behind();
    wr_reg(A_MODE, OVF_F | TGT_F);
    wr_reg(A_CNT, 32'd10);
    wr_reg(A_TGT, 32'd5);
    wr_reg(A_MODE, CNT_EN | TGT_EN);
    step(3);
    chk_reg("R7 behind target count", A_CNT, 32'd13);
    chk_reg("R7 behind target quiet", A_MODE, CNT_EN | TGT_EN);
    wr_reg(A_MODE, 32'h0);
    wr_reg(A_TGT, 32'h1234_0014);
    chk_reg("R7 target low half", A_TGT, 32'h14);
    wr_reg(A_CNT, 32'hABCD_0014);
    chk_reg("R7 count low half", A_CNT, 32'h14);
    wr_reg(A_MODE, CNT_EN | TGT_EN);
    step(4);
    chk_reg("R7 equal count", A_CNT, 32'd24);
    chk_reg("R7 equal target quiet", A_MODE, CNT_EN | TGT_EN);
    wr_reg(A_MODE, 32'h0);
  endtask

  task automatic t_gate_level();
    wr_reg(A_CNT, 32'd7);
    vblank = 1'b1;
    wr_reg(A_MODE, CNT_EN | GATE_EN | SRC_V);
    chk_reg("R9 enable clears", A_CNT, 32'h0);
    step(4);
    chk_reg("R9 paused while high", A_CNT, 32'h0);
    vblank = 1'b0;
    step(3);
    chk_reg("R9 counts while low", A_CNT, 32'd3);
    wr_reg(A_MODE, 32'h0);
  endtask

  task automatic t_gate_edges();
    wr_reg(A_CNT, 32'd9);
    wr_reg(A_MODE, CNT_EN | GATE_EN | SRC_V | GM1);
    chk_reg("R9 mode1 cleared", A_CNT, 32'h0);
    step(3);
    chk_reg("R9 halted before edge", A_CNT, 32'h0);
    vblank = 1'b1;
    step(4);
    chk_reg("R10 mode1 rise restart", A_CNT, 32'd3);
    vblank = 1'b0;
    step(2);
    chk_reg("R10 mode1 fall ignored", A_CNT, 32'd5);
    vblank = 1'b1;
    step(2);
    chk_reg("R10 mode1 second rise", A_CNT, 32'd1);
    vblank = 1'b0;
    wr_reg(A_MODE, CNT_EN | GATE_EN | SRC_V | GM2);
    vblank = 1'b1;
    step(3);
    chk_reg("R10 mode2 rise ignored", A_CNT, 32'h0);
    vblank = 1'b0;
    step(3);
    chk_reg("R10 mode2 fall restart", A_CNT, 32'd2);
    wr_reg(A_MODE, CNT_EN | GATE_EN | SRC_V | GM3);
    vblank = 1'b1;
    step(3);
    chk_reg("R10 mode3 rise", A_CNT, 32'd2);
    vblank = 1'b0;
    step(2);
    chk_reg("R10 mode3 fall", A_CNT, 32'd1);
    wr_reg(A_MODE, 32'h0);
  endtask

  task automatic t_hblank_bypass();
    wr_reg(A_CNT, 32'd4);
    wr_reg(A_MODE, CNT_EN | CSH | GATE_EN | GM1);
    chk_reg("R11 not cleared", A_CNT, 32'd4);
    repeat (2) hpulse();
    chk_reg("R11 counts hblanks", A_CNT, 32'd6);
    wr_reg(A_MODE, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_hold();
    t_clock_sources();
    t_overflow();
    t_same_step();
    t_target();
    t_target_behind();
    t_gate_level();
    t_gate_edges();
    t_hblank_bypass();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule